// File: doc/BRIEF.md
# Special-Register Status-Bit Access Unit

This unit serves decoded move-to and move-from special-register requests from a 32-bit core for a small set of registers. It holds two machine-state bits: the external interrupt enable (EE) and the recoverable-interrupt marker (RI). Three write-only alias register numbers load fixed EE/RI patterns and ignore the write data. A constant, read-only identification word gives the core version in its upper half and the revision in its lower half. All of these registers are supervisor resources. User-mode accesses are refused with a privilege flag. Illegal supervisor accesses raise an unimplemented-instruction flag, which the core turns into a software emulation trap.

The request side is a valid/ready stream. `req_ready` is held high, so the unit never applies back-pressure, and every cycle with `req_valid` high is one accepted request. The result comes one cycle later as a single-cycle pulse on `rd_valid`, `exc_unimpl` or `exc_priv`. The downstream side cannot stall, so the response carries no ready. A register number outside the handled set raises the combinational `not_handled` signal in the request cycle, so that neighbouring special-register logic can answer instead.

Top module: `spr_status_unit`

## Requirements
- R1: After reset, `ee` and `ri` are 0 and `rd_valid`, `exc_unimpl` and `exc_priv` are low.
- R2: A supervisor write to register 80 sets `ee`=1 and `ri`=1 at the next clock edge, whatever the write data.
- R3: A supervisor write to register 81 gives `ee`=0 and `ri`=1 at the next clock edge, whatever the write data.
- R4: A supervisor write to register 82 gives `ee`=0 and `ri`=0 at the next clock edge, whatever the write data.
- R5: A supervisor read of register 80, 81 or 82 pulses `exc_unimpl` one cycle after the request. `rd_valid` stays low and `ee`/`ri` are unchanged.
- R6: A supervisor read of register 287 pulses `rd_valid` one cycle after the request, with `rd_data` = 0x00020020 (version 0x0002 in bits 31:16, revision 0x0020 in bits 15:0).
- R7: A supervisor write to register 287 pulses `exc_unimpl` one cycle after the request and changes no state.
- R8: A user-mode (`req_super`=0) read or write of register 80, 81, 82 or 287 pulses `exc_priv` one cycle after the request. `ee`/`ri` are unchanged and `rd_valid` stays low.
- R9: At most one of `rd_valid`, `exc_unimpl` and `exc_priv` is high in any cycle. Each pulse lasts one cycle per request. A successful alias write raises none of them.
- R10: `not_handled` is high in the request cycle exactly when `req_valid` is high and the register number is outside {80, 81, 82, 287}. Such a request raises no response and changes no state.
- R11: `req_ready` is always high. A cycle with `req_valid` low causes no response and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request acceptance, held high |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_spr | input | 10 | Special-register number |
| req_wdata | input | 32 | Write data (ignored by alias registers) |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data, 0 when `rd_valid` is low |
| exc_unimpl | output | 1 | Unimplemented-instruction exception pulse |
| exc_priv | output | 1 | Privileged-instruction exception pulse |
| not_handled | output | 1 | Combinational: request is for another unit |
| ee | output | 1 | External interrupt enable bit |
| ri | output | 1 | Recoverable-interrupt bit |

## Verification
`not_handled` is combinational, so the bench samples it in the request cycle, one time step after driving the inputs. The response flags, `rd_data`, `ee` and `ri` each pass through exactly one register, so they are due at the first rising edge after the request. The bench drives every request on a falling edge, drops `req_valid` on the next falling edge and samples all registered outputs at that point. It samples once more a cycle later to confirm that each pulse has ended and that the state bits have held.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_ALIAS_RD,
    ACC_ALIAS_WR,
    ACC_VER_RD,
    ACC_VER_WR
  } acc_kind_t;

  typedef struct packed {
    logic ee;
    logic ri;
  } msr_bits_t;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
#(
  parameter int unsigned SPR_W      = 10,
  parameter int unsigned ALIAS_BASE = 80,
  parameter int unsigned ALIAS_CNT  = 3,
  parameter int unsigned VER_NUM    = 287,
  localparam int unsigned IDX_W     = $clog2(ALIAS_CNT)
) (
  input  logic [SPR_W-1:0] spr,
  input  logic             write,
  output acc_kind_t        kind,
  output logic [IDX_W-1:0] alias_idx
);
  logic [ALIAS_CNT-1:0] hit;
  logic                 ver_hit;

  for (genvar g = 0; g < ALIAS_CNT; g++) begin : g_alias
    assign hit[g] = (spr == SPR_W'(ALIAS_BASE + g));
  end

  assign ver_hit = (spr == SPR_W'(VER_NUM));

  always_comb begin
    alias_idx = '0;
    for (int i = 0; i < ALIAS_CNT; i++) begin
      if (hit[i]) alias_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (|hit)        kind = write ? ACC_ALIAS_WR : ACC_ALIAS_RD;
    else if (ver_hit) kind = write ? ACC_VER_WR : ACC_VER_RD;
    else             kind = ACC_NONE;
  end

  always_comb begin
    assert_hit_onehot_R10: assert ($onehot0({hit, ver_hit}));
  end
endmodule

// File: rtl/spr_msr_bits.sv
module spr_msr_bits
  import spr_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] alias_idx,
  output msr_bits_t        bits
);
  msr_bits_t pattern;

  always_comb begin
    case (alias_idx)
      IDX_W'(0): pattern = '{ee: 1'b1, ri: 1'b1};
      IDX_W'(1): pattern = '{ee: 1'b0, ri: 1'b1};
      default:   pattern = '{ee: 1'b0, ri: 1'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bits <= '{ee: 1'b0, ri: 1'b0};
    else if (load) bits <= pattern;
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> bits == $past(bits));
  assert_set_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && alias_idx == IDX_W'(0)) |=> (bits.ee && bits.ri));
  assert_ri_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && alias_idx == IDX_W'(1)) |=> (!bits.ee && bits.ri));
endmodule

// File: rtl/spr_resp.sv
module spr_resp
  import spr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned VER_FIELD = 32'h0002,
  parameter int unsigned REV_FIELD = 32'h0020,
  localparam int unsigned HALF     = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              super_mode,
  input  acc_kind_t         kind,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              exc_unimpl,
  output logic              exc_priv
);
  localparam logic [DATA_W-1:0] VER_WORD =
    {HALF'(VER_FIELD), HALF'(REV_FIELD)};

  logic handled;
  logic good_read;
  logic bad_op;

  assign handled   = (kind != ACC_NONE);
  assign good_read = fire && super_mode && (kind == ACC_VER_RD);
  assign bad_op    = fire && super_mode &&
                     ((kind == ACC_ALIAS_RD) || (kind == ACC_VER_WR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      exc_unimpl <= 1'b0;
      exc_priv   <= 1'b0;
    end else begin
      rd_valid   <= good_read;
      rd_data    <= good_read ? VER_WORD : '0;
      exc_unimpl <= bad_op;
      exc_priv   <= fire && handled && !super_mode;
    end
  end

  assert_one_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, exc_unimpl, exc_priv}));
  assert_data_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !(rd_valid || exc_unimpl || exc_priv));
endmodule

// File: rtl/spr_status_unit.sv
module spr_status_unit
  import spr_pkg::*;
#(
  parameter int unsigned SPR_W      = 10,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ALIAS_BASE = 80,
  parameter int unsigned VER_NUM    = 287,
  parameter int unsigned VER_FIELD  = 32'h0002,
  parameter int unsigned REV_FIELD  = 32'h0020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SPR_W-1:0]  req_spr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_super,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              exc_unimpl,
  output logic              exc_priv,
  output logic              not_handled,
  output logic              ee,
  output logic              ri
);
  localparam int unsigned ALIAS_CNT = 3;
  localparam int unsigned IDX_W     = $clog2(ALIAS_CNT);

  acc_kind_t        kind;
  logic [IDX_W-1:0] alias_idx;
  logic             fire;
  logic             msr_load;
  msr_bits_t        bits;

  assign req_ready   = 1'b1;
  assign fire        = req_valid && req_ready;
  assign not_handled = fire && (kind == ACC_NONE);
  assign msr_load    = fire && req_super && (kind == ACC_ALIAS_WR);

  spr_decode #(
    .SPR_W(SPR_W), .ALIAS_BASE(ALIAS_BASE),
    .ALIAS_CNT(ALIAS_CNT), .VER_NUM(VER_NUM)
  ) u_dec (
    .spr(req_spr), .write(req_write), .kind(kind), .alias_idx(alias_idx)
  );

  spr_msr_bits #(.IDX_W(IDX_W)) u_msr (
    .clk(clk), .rst_n(rst_n), .load(msr_load),
    .alias_idx(alias_idx), .bits(bits)
  );

  spr_resp #(
    .DATA_W(DATA_W), .VER_FIELD(VER_FIELD), .REV_FIELD(REV_FIELD)
  ) u_resp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .super_mode(req_super),
    .kind(kind), .rd_valid(rd_valid), .rd_data(rd_data),
    .exc_unimpl(exc_unimpl), .exc_priv(exc_priv)
  );

  assign ee = bits.ee;
  assign ri = bits.ri;

  assert_user_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_super && !not_handled)
      |=> (exc_priv && ee == $past(ee) && ri == $past(ri)));
  assert_clear_ignores_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_super && req_write && req_spr == SPR_W'(ALIAS_BASE + 2)
      && req_wdata != '0) |=> (!ee && !ri));
  assert_alias_read_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_super && !req_write && req_spr == SPR_W'(ALIAS_BASE + 1))
      |=> (exc_unimpl && !rd_valid && $stable(ee) && $stable(ri)));
  assert_foreign_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    not_handled |=> (!rd_valid && !exc_unimpl && !exc_priv && $stable(ee) && $stable(ri)));
  assert_ver_write_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_super && req_write && req_spr == SPR_W'(VER_NUM))
      |=> (exc_unimpl && $stable(ee) && $stable(ri)));
endmodule

// File: tb/sim_spr_status_unit.sv
`timescale 1ns/1ps
module sim_spr_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [9:0]  req_spr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_super = 1'b0;
  logic        rd_valid, exc_unimpl, exc_priv, not_handled, ee, ri;
  logic [31:0] rd_data;

  int tests = 0;
  int fails = 0;

  logic        s_nh, s_rv, s_un, s_pr, s_ee, s_ri;
  logic [31:0] s_rd;

  always #10 clk = ~clk;

  spr_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_spr(req_spr), .req_wdata(req_wdata),
    .req_super(req_super), .rd_valid(rd_valid), .rd_data(rd_data),
    .exc_unimpl(exc_unimpl), .exc_priv(exc_priv), .not_handled(not_handled),
    .ee(ee), .ri(ri)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; not_handled sampled in request cycle, registered outputs one cycle later
  task automatic issue(input logic w, input logic [9:0] spr, input logic [31:0] d, input logic sup);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_spr = spr; req_wdata = d; req_super = sup;
    #1 s_nh = not_handled;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = '0;
    s_rv = rd_valid; s_rd = rd_data; s_un = exc_unimpl; s_pr = exc_priv;
    s_ee = ee; s_ri = ri;
  endtask

  task automatic chk_quiet(input string tag);
    @(negedge clk);
    chk(tag, {29'd0, rd_valid, exc_unimpl, exc_priv}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 ee/ri", {30'd0, ee, ri}, 32'd0);
    chk("R1 flags", {29'd0, rd_valid, exc_unimpl, exc_priv}, 32'd0);
    chk("R11 ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_alias_writes;
    issue(1'b1, 10'd80, 32'h0000_0000, 1'b1);
    chk("R2 ee/ri", {30'd0, s_ee, s_ri}, 32'd3);
    chk("R9 no flag on alias write", {29'd0, s_rv, s_un, s_pr}, 32'd0);
    chk("R10 nh low for alias", {31'd0, s_nh}, 32'd0);
    issue(1'b1, 10'd81, 32'hFFFF_FFFF, 1'b1);
    chk("R3 ee/ri", {30'd0, s_ee, s_ri}, 32'd1);
    issue(1'b1, 10'd82, 32'hA5A5_5A5A, 1'b1);
    chk("R4 ee/ri", {30'd0, s_ee, s_ri}, 32'd0);
    issue(1'b1, 10'd81, 32'h0, 1'b1);
    issue(1'b1, 10'd80, 32'h1234_5678, 1'b1);
    chk("R2 from ri-only", {30'd0, s_ee, s_ri}, 32'd3);
  endtask

  task automatic t_alias_reads;
    for (int i = 80; i <= 82; i++) begin
      issue(1'b0, 10'(i), 32'h0, 1'b1);
      chk("R5 unimpl", {29'd0, s_rv, s_un, s_pr}, 32'd2);
      chk("R5 state kept", {30'd0, s_ee, s_ri}, 32'd3);
      chk_quiet("R9 pulse ends after alias read");
    end
  endtask

  task automatic t_version_read;
    issue(1'b0, 10'd287, 32'h0, 1'b1);
    chk("R6 valid", {29'd0, s_rv, s_un, s_pr}, 32'd4);
    chk("R6 data", s_rd, 32'h0002_0020);
    chk_quiet("R9 pulse ends after version read");
    chk("R6 data cleared", rd_data, 32'h0);
  endtask

  task automatic t_version_write;
    issue(1'b1, 10'd287, 32'hDEAD_BEEF, 1'b1);
    chk("R7 unimpl", {29'd0, s_rv, s_un, s_pr}, 32'd2);
    chk("R7 state kept", {30'd0, s_ee, s_ri}, 32'd3);
    issue(1'b0, 10'd287, 32'h0, 1'b1);
    chk("R7 version unchanged", s_rd, 32'h0002_0020);
  endtask

  task automatic t_user_mode;
    issue(1'b1, 10'd82, 32'h0, 1'b0);
    chk("R8 priv on alias write", {29'd0, s_rv, s_un, s_pr}, 32'd1);
    chk("R8 state kept", {30'd0, s_ee, s_ri}, 32'd3);
    issue(1'b0, 10'd80, 32'h0, 1'b0);
    chk("R8 priv on alias read", {29'd0, s_rv, s_un, s_pr}, 32'd1);
    issue(1'b0, 10'd287, 32'h0, 1'b0);
    chk("R8 priv on version read", {29'd0, s_rv, s_un, s_pr}, 32'd1);
    chk("R8 no data", s_rd, 32'h0);
    issue(1'b1, 10'd287, 32'h0, 1'b0);
    chk("R8 priv on version write", {29'd0, s_rv, s_un, s_pr}, 32'd1);
    chk_quiet("R9 pulse ends after priv");
  endtask

  task automatic t_unhandled;
    issue(1'b1, 10'd83, 32'h0, 1'b1);
    chk("R10 nh high", {31'd0, s_nh}, 32'd1);
    chk("R10 no response", {29'd0, s_rv, s_un, s_pr}, 32'd0);
    chk("R10 state kept", {30'd0, s_ee, s_ri}, 32'd3);
    issue(1'b0, 10'd79, 32'h0, 1'b0);
    chk("R10 nh user", {31'd0, s_nh}, 32'd1);
    chk("R10 no priv", {29'd0, s_rv, s_un, s_pr}, 32'd0);
    issue(1'b0, 10'd286, 32'h0, 1'b1);
    chk("R10 nh below version", {31'd0, s_nh}, 32'd1);
    @(negedge clk);
    chk("R10 nh low when idle", {31'd0, not_handled}, 32'd0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_write = 1'b1; req_spr = 10'd82; req_super = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 idle no change", {30'd0, ee, ri}, 32'd3);
    chk("R11 idle no flags", {29'd0, rd_valid, exc_unimpl, exc_priv}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_alias_writes();
    t_alias_reads();
    t_version_read();
    t_version_write();
    t_user_mode();
    t_unhandled();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule